// File: doc/BRIEF.md
# LIN Frame Checksum Engine

This block builds and verifies the checksum byte of a LIN message frame at byte level. A framing receiver or transmitter upstream hands it the bytes of one frame in bus order, each with a one-cycle strobe. A frame-start pulse clears the running sum and captures the data length code. The identifier byte follows. The data bytes come next, then a received checksum byte when the node is listening.

Every byte that the sum covers is folded in with an end-around carry. The carry out of the top bit is added back into bit 0. The checksum to transmit is the bitwise inverse of this sum. A mode input selects one of two calculations, and it is sampled when the identifier byte is accepted. The classic calculation covers only the data bytes. The enhanced calculation adds the identifier first. A received checksum byte is folded into the sum, and the block raises a one-cycle ok or error pulse depending on whether the result is all ones. Strobes that arrive outside their place in the frame do not change the sum. They set a sticky protocol flag instead.

Top module: `lin_cks_top`

## Requirements
- R1: Each covered byte is added to the 8-bit running sum with end-around carry: the 9-bit sum's bit 8 is added back into bit 0 (for example 0xFF plus 0x01 gives 0x01).
- R2: `cks_out` always shows the bitwise inverse of the running sum, so it reads 0xFF in the cycle after reset or after a frame-start pulse.
- R3: When `mode_enh` is 0 at identifier acceptance (classic), the identifier byte does not enter the sum, and the sum starts with the first data byte.
- R4: When `mode_enh` is 1 at identifier acceptance (enhanced), the identifier byte is the first value summed, followed by the data bytes in bus order.
- R5: The mode is sampled only in the cycle the identifier strobe is accepted. Changing `mode_enh` later in the frame leaves `cks_out` unchanged.
- R6: `dlc` is captured at frame start. A value of 0 is taken as 1, and a value above 8 is taken as 8. `cks_done` goes high in the cycle after the last data byte is accepted and stays high until the next frame start.
- R7: A checksum strobe while `cks_done` is high adds `chk_byte` to the sum with end-around carry. In the next cycle exactly one of `chk_ok` (result 0xFF) or `chk_err` (any other result) is high, for one cycle only.
- R8: Strobes that arrive out of place change neither `cks_out` nor the pulses, and they set `proto_err`. This covers data or checksum strobes before any frame start, a data strobe before the identifier, a data strobe after the last counted byte, a checksum strobe before `cks_done`, and a second checksum strobe in the same frame.
- R9: `proto_err` stays set until a frame-start pulse clears it. A frame-start pulse takes priority over any strobe in the same cycle, and that strobe is dropped without being flagged.
- R10: After reset `cks_done`, `chk_ok`, `chk_err` and `proto_err` are low and `cks_out` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| dlc | input | 4 | Data length code, captured at frame start |
| mode_enh | input | 1 | 1 selects the enhanced calculation, sampled with the identifier |
| id_valid | input | 1 | Identifier byte strobe |
| id_byte | input | 8 | Protected identifier byte |
| data_valid | input | 1 | Data byte strobe |
| data_byte | input | 8 | Data byte |
| chk_valid | input | 1 | Received checksum strobe |
| chk_byte | input | 8 | Received checksum byte |
| cks_out | output | 8 | Inverted running sum, the checksum to transmit |
| cks_done | output | 1 | All data bytes of the frame have been summed |
| chk_ok | output | 1 | One-cycle pulse: received checksum matches |
| chk_err | output | 1 | One-cycle pulse: received checksum mismatch |
| proto_err | output | 1 | Sticky flag for an out-of-place strobe |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a maximum of eight data bytes and a 4-bit length code. The code width can carry values that need clamping (0 and 9 to 15), so random frames reach both clamp paths as well as every legal length. With 8-bit bytes, random data often produces end-around carries, and sums of 0xFF show up as well. This lets the bench compare the wrap behaviour and the all-ones match against its own model.

// File: rtl/lin_cks_pkg.sv
package lin_cks_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // no frame open
    ST_ID   = 3'd1,  // waiting for identifier
    ST_DATA = 3'd2,  // collecting data bytes
    ST_CHK  = 3'd3,  // sum complete, waiting for received checksum
    ST_FIN  = 3'd4   // checksum compared, frame closed
  } frm_state_e;

endpackage

// File: rtl/lin_cks_eac_add.sv
module lin_cks_eac_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    // fold the carry back into the least significant bit
    y   = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/lin_cks_ctrl.sv
module lin_cks_ctrl
  import lin_cks_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int DLC_W   = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [DLC_W-1:0] dlc,
  input  logic             mode_enh,
  input  logic             id_valid,
  input  logic             data_valid,
  input  logic             chk_valid,
  output logic             acc_clr,
  output logic             acc_en,
  output logic             acc_sel_id,
  output logic             chk_fire,
  output logic             frm_done,
  output logic             proto_err
);

  frm_state_e       st_q, st_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0] cnt_inc;
  logic [LEN_W-1:0] len_clamp;
  logic             perr_q, perr_n;
  logic             perr_set;

  // length code clamped into 1..MAX_LEN
  always_comb begin
    if (int'(dlc) == 0)            len_clamp = LEN_W'(1);
    else if (int'(dlc) > MAX_LEN)  len_clamp = LEN_W'(MAX_LEN);
    else                           len_clamp = LEN_W'(dlc);
  end

  assign cnt_inc = cnt_q + LEN_W'(1);

  always_comb begin
    st_n       = st_q;
    len_n      = len_q;
    cnt_n      = cnt_q;
    acc_clr    = 1'b0;
    acc_en     = 1'b0;
    acc_sel_id = 1'b0;
    chk_fire   = 1'b0;
    perr_set   = 1'b0;
    if (frame_start) begin
      st_n    = ST_ID;
      len_n   = len_clamp;
      cnt_n   = '0;
      acc_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          perr_set = data_valid | chk_valid;
        end
        ST_ID: begin
          perr_set = data_valid | chk_valid;
          if (id_valid) begin
            st_n = ST_DATA;
            if (mode_enh) begin
              acc_en     = 1'b1;
              acc_sel_id = 1'b1;
            end
          end
        end
        ST_DATA: begin
          perr_set = chk_valid;
          if (data_valid) begin
            acc_en = 1'b1;
            cnt_n  = cnt_inc;
            if (cnt_inc == len_q) st_n = ST_CHK;
          end
        end
        ST_CHK: begin
          perr_set = data_valid;
          if (chk_valid) begin
            chk_fire = 1'b1;
            st_n     = ST_FIN;
          end
        end
        ST_FIN: begin
          perr_set = data_valid | chk_valid;
        end
        default: st_n = ST_IDLE;
      endcase
    end
    perr_n = frame_start ? 1'b0 : (perr_q | perr_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      cnt_q  <= '0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      len_q  <= len_n;
      cnt_q  <= cnt_n;
      perr_q <= perr_n;
    end
  end

  assign frm_done  = (st_q == ST_CHK) || (st_q == ST_FIN);
  assign proto_err = perr_q;

endmodule

// File: rtl/lin_cks_acc.sv
module lin_cks_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         sel_id,
  input  logic [W-1:0] id_byte,
  input  logic [W-1:0] data_byte,
  output logic [W-1:0] sum
);
  logic [W-1:0] sum_q, sum_n, operand, added;

  assign operand = sel_id ? id_byte : data_byte;

  lin_cks_eac_add #(.W(W)) u_add (
    .a (sum_q),
    .b (operand),
    .y (added)
  );

  always_comb begin
    sum_n = sum_q;
    if (clr)     sum_n = '0;
    else if (en) sum_n = added;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_n;
  end

  assign sum = sum_q;
endmodule

// File: rtl/lin_cks_cmp.sv
module lin_cks_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] sum,
  input  logic [W-1:0] rx_byte,
  output logic         ok,
  output logic         err
);
  logic [W-1:0] total;
  logic         ok_q, ok_n, err_q, err_n;

  lin_cks_eac_add #(.W(W)) u_add (
    .a (sum),
    .b (rx_byte),
    .y (total)
  );

  always_comb begin
    ok_n  = fire && (total == {W{1'b1}});
    err_n = fire && (total != {W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ok_q  <= ok_n;
      err_q <= err_n;
    end
  end

  assign ok  = ok_q;
  assign err = err_q;
endmodule

// File: rtl/lin_cks_top.sv
module lin_cks_top #(
  parameter int BYTE_W  = 8,
  parameter int MAX_LEN = 8,
  parameter int DLC_W   = 4,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [DLC_W-1:0]  dlc,
  input  logic              mode_enh,
  input  logic              id_valid,
  input  logic [BYTE_W-1:0] id_byte,
  input  logic              data_valid,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              chk_valid,
  input  logic [BYTE_W-1:0] chk_byte,
  output logic [BYTE_W-1:0] cks_out,
  output logic              cks_done,
  output logic              chk_ok,
  output logic              chk_err,
  output logic              proto_err
);

  // reset asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  logic              acc_clr, acc_en, acc_sel_id, chk_fire;
  logic [BYTE_W-1:0] sum;

  lin_cks_ctrl #(.MAX_LEN(MAX_LEN), .DLC_W(DLC_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .dlc         (dlc),
    .mode_enh    (mode_enh),
    .id_valid    (id_valid),
    .data_valid  (data_valid),
    .chk_valid   (chk_valid),
    .acc_clr     (acc_clr),
    .acc_en      (acc_en),
    .acc_sel_id  (acc_sel_id),
    .chk_fire    (chk_fire),
    .frm_done    (cks_done),
    .proto_err   (proto_err)
  );

  lin_cks_acc #(.W(BYTE_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (acc_clr),
    .en        (acc_en),
    .sel_id    (acc_sel_id),
    .id_byte   (id_byte),
    .data_byte (data_byte),
    .sum       (sum)
  );

  lin_cks_cmp #(.W(BYTE_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (chk_fire),
    .sum     (sum),
    .rx_byte (chk_byte),
    .ok      (chk_ok),
    .err     (chk_err)
  );

  assign cks_out = ~sum;

endmodule

// File: rtl/lin_cks_sva.sv
module lin_cks_sva #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              data_valid,
  input logic              chk_valid,
  input logic [BYTE_W-1:0] cks_out,
  input logic              cks_done,
  input logic              chk_ok,
  input logic              chk_err,
  input logic              proto_err
);

  AST_OK_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_ok && chk_err));  // R7

  AST_OK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |=> !chk_ok);  // R7

  AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |=> !chk_err);  // R7

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cks_out == {BYTE_W{1'b1}}) && !cks_done && !proto_err);  // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cks_done && !frame_start) |=> cks_done);  // R6

  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && !frame_start) |=> proto_err);  // R9

  AST_LATE_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cks_done && data_valid && !frame_start) |=> (proto_err && $stable(cks_out)));  // R8

  AST_EARLY_CHK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cks_done && chk_valid && !frame_start) |=> (proto_err && !chk_ok && !chk_err));  // R8

endmodule

bind lin_cks_top lin_cks_sva #(.BYTE_W(BYTE_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .frame_start (frame_start),
  .data_valid  (data_valid),
  .chk_valid   (chk_valid),
  .cks_out     (cks_out),
  .cks_done    (cks_done),
  .chk_ok      (chk_ok),
  .chk_err     (chk_err),
  .proto_err   (proto_err)
);

// File: tb/tb_lin_cks_top.sv
module tb_lin_cks_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_start, mode_enh, id_valid, data_valid, chk_valid;
  logic [3:0] dlc;
  logic [7:0] id_byte, data_byte, chk_byte;
  logic [7:0] cks_out;
  logic       cks_done, chk_ok, chk_err, proto_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_cks_top dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dlc(dlc),
    .mode_enh(mode_enh), .id_valid(id_valid), .id_byte(id_byte),
    .data_valid(data_valid), .data_byte(data_byte), .chk_valid(chk_valid),
    .chk_byte(chk_byte), .cks_out(cks_out), .cks_done(cks_done),
    .chk_ok(chk_ok), .chk_err(chk_err), .proto_err(proto_err)
  );

  function automatic logic [7:0] eac(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  function automatic int clamp_len(input logic [3:0] c);
    if (c == 0) return 1;
    if (c > 8)  return 8;
    return int'(c);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    frame_start = 1'b0;
    id_valid    = 1'b0;
    data_valid  = 1'b0;
    chk_valid   = 1'b0;
  endtask

  task automatic open_frame(input logic [3:0] code);
    frame_start = 1'b1; dlc = code;
    step();
    chk("R2 start cks_out", cks_out, 8'hFF);
    chk("R9 start clears proto_err", {7'd0, proto_err}, 8'd0);
  endtask

  // one full frame; returns nothing, checks inside
  task automatic run_frame(input logic enh, input logic [3:0] code, input logic [7:0] idb,
                           input logic bad, input logic flip);
    logic [7:0] sum;
    logic [7:0] rx;
    int n;
    open_frame(code);
    n = clamp_len(code);
    sum = enh ? eac(8'h00, idb) : 8'h00;
    id_valid = 1'b1; id_byte = idb; mode_enh = enh;
    step();
    if (flip) mode_enh = ~enh;
    for (int i = 0; i < n; i++) begin
      data_valid = 1'b1; data_byte = 8'($urandom);
      sum = eac(sum, data_byte);
      step();
      if (i < n - 1) chk("R6 done early", {7'd0, cks_done}, 8'd0);
    end
    chk("R6 done after last byte", {7'd0, cks_done}, 8'd1);
    chk(enh ? (flip ? "R5 R4 enhanced sum" : "R4 R1 enhanced sum")
            : (flip ? "R5 R3 classic sum"  : "R3 R1 classic sum"), cks_out, ~sum);
    rx = bad ? (~sum ^ (8'($urandom_range(1, 255)))) : ~sum;
    chk_valid = 1'b1; chk_byte = rx;
    step();
    chk("R7 ok pulse",  {7'd0, chk_ok},  {7'd0, eac(sum, rx) == 8'hFF});
    chk("R7 err pulse", {7'd0, chk_err}, {7'd0, eac(sum, rx) != 8'hFF});
    step();
    chk("R7 pulse one cycle", {6'd0, chk_ok, chk_err}, 8'd0);
    chk("R6 done held", {7'd0, cks_done}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    void'($urandom(32'd1234));
    rst_n = 1'b0; frame_start = 0; id_valid = 0; data_valid = 0; chk_valid = 0;
    mode_enh = 0; dlc = 4'd1; id_byte = 0; data_byte = 0; chk_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cks_out", cks_out, 8'hFF);
    chk("R10 flags", {4'd0, cks_done, chk_ok, chk_err, proto_err}, 8'd0);

    // R8 strobes before any frame start
    data_valid = 1; data_byte = 8'h55; step();
    chk("R8 pre-start data cks_out", cks_out, 8'hFF);
    chk("R8 pre-start proto_err", {7'd0, proto_err}, 8'd1);
    chk_valid = 1; chk_byte = 8'h00; step();
    chk("R8 pre-start chk no pulse", {6'd0, chk_ok, chk_err}, 8'd0);

    // R1 wrap: classic, 0xFF + 0x01 -> 0x01, checksum 0xFE
    open_frame(4'd2);
    id_valid = 1; id_byte = 8'h3C; mode_enh = 0; step();
    chk("R3 id not summed", cks_out, 8'hFF);
    data_valid = 1; data_byte = 8'h01; step();
    // data before done: checksum early -> ignored
    chk_valid = 1; chk_byte = 8'h00; step();
    chk("R8 early chk proto_err", {7'd0, proto_err}, 8'd1);
    chk("R8 early chk no pulse", {6'd0, chk_ok, chk_err}, 8'd0);
    data_valid = 1; data_byte = 8'hFF; step();
    chk("R1 end-around carry", cks_out, 8'hFE);
    chk_valid = 1; chk_byte = 8'hFE; step();
    chk("R7 match ok", {7'd0, chk_ok}, 8'd1);
    step();
    // second checksum strobe ignored
    chk_valid = 1; chk_byte = 8'hFE; step();
    chk("R8 second chk no pulse", {6'd0, chk_ok, chk_err}, 8'd0);
    // data beyond length ignored
    hold = cks_out;
    data_valid = 1; data_byte = 8'h20; step();
    chk("R8 late data cks_out", cks_out, hold);
    chk("R9 proto_err sticky", {7'd0, proto_err}, 8'd1);

    // R8 data before identifier
    open_frame(4'd1);
    data_valid = 1; data_byte = 8'h11; step();
    chk("R8 data before id", cks_out, 8'hFF);
    chk("R8 data before id flag", {7'd0, proto_err}, 8'd1);

    // R9 frame start wins over same-cycle data
    frame_start = 1; dlc = 4'd1; data_valid = 1; data_byte = 8'h77; step();
    chk("R9 start priority cks_out", cks_out, 8'hFF);
    chk("R9 start priority no flag", {7'd0, proto_err}, 8'd0);

    // R6 clamps and R4 enhanced directed
    run_frame(1'b1, 4'd0,  8'h80, 1'b0, 1'b0);
    run_frame(1'b0, 4'd15, 8'h80, 1'b1, 1'b0);
    run_frame(1'b1, 4'd9,  8'hFF, 1'b0, 1'b1);

    for (int k = 0; k < 300; k++)
      run_frame(1'($urandom), 4'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule